// File: doc/BRIEF.md
# Segmented Prefix-Carry Adder

This block adds two 16-bit unsigned operands and a one-bit carry-in, and returns a 16-bit sum with a carry-out. It has no clock and no state. A result is valid as soon as the inputs have settled.

The width is cut into four 4-bit slices, and each slice is a short ripple chain of full adders. A pruned parallel-prefix tree works out, in a logarithmic number of combine levels, only the three carries that enter the upper slices. All four slices therefore start rippling together. The carry-in joins the tree only at the last step, where it is merged into each boundary carry through that boundary's group propagate.

Typical use is inside a wider datapath that needs a fast 16-bit add but cannot pay the gate count of a full prefix tree.

Top module: `seg_prefix_adder`

## Requirements
- R1: For every input, {cout, sum} equals the 17-bit unsigned value a + b + cin.
- R2: sum[3:0] equals the low four bits of a[3:0] + b[3:0] + cin, so the lowest slice takes the external carry-in directly.
- R3: The carries entering bit 4, bit 8 and bit 12 each equal the carry out of the unsigned sum of all lower operand bits plus cin.
- R4: Each upper slice (sum[7:4], sum[11:8], sum[15:12]) equals the low four bits of its two operand nibbles plus the boundary carry entering that slice.
- R5: When every bit position propagates (b equals the bitwise inverse of a), cout equals cin, and sum is all ones when cin is 0 and all zeros when cin is 1.
- R6: When both operands are zero, sum equals cin zero-extended and cout is 0.
- R7: With both operands all ones and cin set to 1, the result is sum = 16'hFFFF and cout = 1.
- R8: The outputs depend only on the present inputs: no clock, no latch and no stored state, so a new result appears in the same time step as the input change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | First addend |
| b | input | 16 | Second addend |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 16 | Low 16 bits of a + b + cin |
| cout | output | 1 | Carry out of bit 15 |

## Verification
Every result is due in the same clock period as its stimulus, with zero register stages between input and output. The driver applies operands on a falling edge and queues the expected 17-bit total. The monitor pops that total and compares it at the next rising edge, half a period later, once the combinational paths have settled. Directed vectors aim carry chains at each slice boundary, and a long run of random vectors covers everything else.

// File: rtl/seg_prefix_adder.sv
module seg_prefix_adder (
  input  logic [15:0] a,
  input  logic [15:0] b,
  input  logic        cin,
  output logic [15:0] sum,
  output logic        cout
);
  localparam int W    = 16;
  localparam int SEG  = 4;
  localparam int NSEG = W / SEG;

  function automatic logic [1:0] pg_merge(input logic [1:0] hi, input logic [1:0] lo);
    return {hi[1] | (hi[0] & lo[1]), hi[0] & lo[0]};
  endfunction

  logic [W-1:0] g, p;
  assign g = a & b;
  assign p = a ^ b;

  logic [1:0] gp [W];
  for (genvar i = 0; i < W; i++) begin : g_pair
    assign gp[i] = {g[i], p[i]};
  end

  logic [1:0] l1_1, l1_3, l1_5, l1_7, l1_9, l1_11;
  assign l1_1  = pg_merge(gp[1],  gp[0]);
  assign l1_3  = pg_merge(gp[3],  gp[2]);
  assign l1_5  = pg_merge(gp[5],  gp[4]);
  assign l1_7  = pg_merge(gp[7],  gp[6]);
  assign l1_9  = pg_merge(gp[9],  gp[8]);
  assign l1_11 = pg_merge(gp[11], gp[10]);

  logic [1:0] l2_3, l2_7, l2_11;
  assign l2_3  = pg_merge(l1_3,  l1_1);
  assign l2_7  = pg_merge(l1_7,  l1_5);
  assign l2_11 = pg_merge(l1_11, l1_9);

  logic [1:0] l3_7, l3_11, l4_11;
  assign l3_7  = pg_merge(l2_7,  l2_3);
  assign l3_11 = pg_merge(l2_11, l2_7);
  assign l4_11 = pg_merge(l3_11, l2_3);

  logic [NSEG-1:0] seg_cin;
  assign seg_cin[0] = cin;
  assign seg_cin[1] = l2_3[1]  | (l2_3[0]  & cin);
  assign seg_cin[2] = l3_7[1]  | (l3_7[0]  & cin);
  assign seg_cin[3] = l4_11[1] | (l4_11[0] & cin);

  always_comb begin
    logic c;
    c = 1'b0;
    sum = '0;
    for (int s = 0; s < NSEG; s++) begin
      c = seg_cin[s];
      for (int j = 0; j < SEG; j++) begin
        sum[s*SEG+j] = p[s*SEG+j] ^ c;
        c = g[s*SEG+j] | (p[s*SEG+j] & c);
      end
    end
    cout = c;
  end
endmodule

// File: rtl/seg_prefix_adder_chk.sv
module seg_prefix_adder_chk (
  input logic [15:0] a,
  input logic [15:0] b,
  input logic        cin,
  input logic [15:0] sum,
  input logic        cout,
  input logic [3:0]  seg_cin
);
  logic [16:0] total;
  logic [4:0]  low4, low8, low12;
  logic [8:0]  low8w;
  logic [12:0] low12w;

  always_comb begin
    total  = {1'b0, a} + {1'b0, b} + {16'b0, cin};
    low4   = {1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'b0, cin};
    low8w  = {1'b0, a[7:0]} + {1'b0, b[7:0]} + {8'b0, cin};
    low12w = {1'b0, a[11:0]} + {1'b0, b[11:0]} + {12'b0, cin};
    low8   = {low8w[8], 4'b0};
    low12  = {low12w[12], 4'b0};

    assert_total_R1: assert ({cout, sum} == total)
      else $error("R1 total mismatch");
    assert_low_slice_R2: assert (sum[3:0] == low4[3:0])
      else $error("R2 low slice mismatch");
    assert_boundary_R3: assert (seg_cin[1] == low4[4] && seg_cin[2] == low8[4]
                                && seg_cin[3] == low12[4] && seg_cin[0] == cin)
      else $error("R3 boundary carry mismatch");
    assert_upper_slices_R4: assert (
      sum[7:4]   == 4'(a[7:4]   + b[7:4]   + {3'b0, seg_cin[1]}) &&
      sum[11:8]  == 4'(a[11:8]  + b[11:8]  + {3'b0, seg_cin[2]}) &&
      sum[15:12] == 4'(a[15:12] + b[15:12] + {3'b0, seg_cin[3]}))
      else $error("R4 upper slice mismatch");
    if ((a ^ b) == 16'hFFFF) begin
      assert_full_propagate_R5: assert (cout == cin && sum == {16{~cin}})
        else $error("R5 propagate chain mismatch");
    end
    if (a == 16'h0 && b == 16'h0) begin
      assert_zero_operands_R6: assert (cout == 1'b0 && sum == {15'b0, cin})
        else $error("R6 zero operand mismatch");
    end
  end
endmodule

bind seg_prefix_adder seg_prefix_adder_chk u_chk (
  .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout), .seg_cin(seg_cin)
);

// File: tb/tb_seg_prefix_adder.sv
module tb_seg_prefix_adder;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [15:0] a = '0, b = '0;
  logic        cin = 1'b0;
  logic [15:0] sum;
  logic        cout;

  seg_prefix_adder dut (.a(a), .b(b), .cin(cin), .sum(sum), .cout(cout));

  typedef struct {
    logic [15:0] a;
    logic [15:0] b;
    logic        cin;
    logic [16:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic send(input logic [15:0] va, input logic [15:0] vb, input logic vc, input string req);
    item_t it;
    @(negedge clk);
    a = va; b = vb; cin = vc;
    it.a = va; it.b = vb; it.cin = vc; it.req = req;
    it.exp = {1'b0, va} + {1'b0, vb} + {16'b0, vc};
    q.push_back(it);
  endtask

  always @(posedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_cmp++;
      if ({cout, sum} !== it.exp) begin
        n_bad++;
        $display("FAIL %s a=%h b=%h cin=%0d actual=%h expected=%h",
                 it.req, it.a, it.b, it.cin, {cout, sum}, it.exp);
      end
    end
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    int cycles = 0;
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_bad++;
        $display("FAIL watchdog actual=hung expected=complete");
        finish_run();
      end
    end
  end

  initial begin
    // R8: idle inputs settle to a zero result with no clocked state
    send(16'h0000, 16'h0000, 1'b0, "R8 idle");
    send(16'h0000, 16'h0000, 1'b1, "R6 zero+cin");
    send(16'h0000, 16'h0000, 1'b0, "R6 zero");
    send(16'hFFFF, 16'hFFFF, 1'b1, "R7 all ones");
    send(16'hFFFF, 16'hFFFF, 1'b0, "R7 all ones no cin");
    send(16'hAAAA, 16'h5555, 1'b1, "R5 alternating cin1");
    send(16'hAAAA, 16'h5555, 1'b0, "R5 alternating cin0");
    send(16'h1234, 16'hEDCB, 1'b1, "R5 inverse pair");
    send(16'hAAAA, 16'hAAAA, 1'b0, "R1 alternating");
    send(16'h5555, 16'h5555, 1'b1, "R1 alternating");
    send(16'h000F, 16'h0000, 1'b1, "R2 low slice wrap");
    send(16'h0007, 16'h0009, 1'b0, "R2 low slice carry");
    send(16'h000F, 16'h0001, 1'b0, "R3 carry into bit 4");
    send(16'h00FF, 16'h0000, 1'b1, "R3 carry into bit 8");
    send(16'h0FFF, 16'h0000, 1'b1, "R3 carry into bit 12");
    send(16'h0FF0, 16'h0010, 1'b0, "R3 chain 4 to 12");
    send(16'hFFFF, 16'h0001, 1'b0, "R1 full chain");
    send(16'hF0F0, 16'h0F10, 1'b0, "R4 slice carries");
    send(16'h8888, 16'h8888, 1'b1, "R4 slice tops");
    send(16'h7FFF, 16'h0001, 1'b0, "R4 top slice");
    for (int i = 0; i < 16; i++) begin
      send(16'hFFFF >> i, 16'h0001 << (15 - i), 1'b0, "R3 walking chain");
      send(16'h0001 << i, 16'h0001 << i, 1'b1, "R1 walking bit");
    end
    for (int i = 0; i < 100000; i++) begin
      send(16'($urandom), 16'($urandom), 1'($urandom), "R1 random");
    end
    @(negedge clk);
    @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule